// File: doc/BRIEF.md
# Adaptive Prefetch Throttle for a Second-Level Cache

This block sits next to the tag pipeline of a second-level cache and decides, cycle by cycle, whether a stream prefetch candidate may take the tag port. Demand lookups from the first-level cache always own the port. A prefetch candidate is granted only in a cycle that demand leaves idle, only while the miss queue has room, and only while the current prefetch degree is non-zero. A candidate needs no earlier miss on its stream to be granted.

The block also sets the prefetch degree, which the stream engine uses as its lookahead. Demand traffic is counted over fixed windows. A window with heavy demand, or one that ends with a well-filled miss queue, lowers the degree by one step, so back-off takes many busy windows. A window with no demand at all sets the degree straight back to its maximum. A window with light but non-zero demand raises it by one step.

Top module: `pf_throttle`

## Requirements
- R1: While reset is asserted and after it is released, the degree output reads its maximum value (all ones, 7 with the default 3-bit width).
- R2: `pf_grant` is high in the same cycle that `pf_req` is high, `dmd_valid` is low, `mq_count` is below `MQ_DEPTH-1` and the degree is non-zero. It is low in every other cycle.
- R3: A demand lookup always takes precedence: `pf_grant` is low in every cycle where `dmd_valid` is high.
- R4: `pf_grant` is low whenever `mq_count` is `MQ_DEPTH-1` (15 by default) or more.
- R5: A window is `WIN_LEN` cycles long (64 by default) and starts with the first clock edge after reset is released. The window total counts the cycles of that window in which `dmd_valid` was high, including the window's last cycle. The window is busy if the total is `thr_hi` or more, or if `mq_count` in the window's last cycle is `MQ_BUSY` (12 by default) or more. A busy window lowers the degree by one, with a floor of 0. This check has the highest priority.
- R6: A window that is not busy and has a total of zero sets the degree to its maximum.
- R7: A window that is not busy and has a total from 1 up to and including `thr_lo` raises the degree by one, with a ceiling at the maximum.
- R8: Any other window leaves the degree unchanged.
- R9: With the default `ZERO_STOP=1`, a degree of zero blocks every grant.
- R10: The degree changes only at the clock edge that ends a window. The new value is visible directly after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dmd_valid | input | 1 | A demand lookup uses the tag port in this cycle |
| mq_count | input | $clog2(MQ_DEPTH+1) | Current miss-queue occupancy |
| thr_hi | input | $clog2(WIN_LEN+1) | Window total at or above which the window is busy |
| thr_lo | input | $clog2(WIN_LEN+1) | Largest non-zero window total that counts as quiet |
| pf_req | input | 1 | A prefetch candidate asks for a tag lookup |
| pf_grant | output | 1 | The prefetch lookup may use the tag port in this cycle |
| pf_degree | output | DEG_W | Current prefetch degree |

## Verification
The grant is combinational, so it is due in the same cycle as its inputs. The bench drives the inputs at the falling edge and checks the grant shortly afterwards, on every cycle of every window. The degree register updates on the 64th rising edge after the window started, and the bench samples it at the falling edge that follows. All stimulus advances in whole windows, so a reference model in the bench stays aligned with the design's window boundaries. Window totals are swept across zero, both thresholds and their neighbours, saturation at both ends of the degree range, and the queue-fill trigger. The queue-occupancy pattern inside each window covers the full 0 to 16 range under alternating requests.

// File: rtl/pf_throttle_pkg.sv
package pf_throttle_pkg;
   typedef enum logic [1:0] {
      VERD_HOLD = 2'd0,
      VERD_DOWN = 2'd1,
      VERD_UP   = 2'd2,
      VERD_FULL = 2'd3
   } pf_verdict_e;
endpackage

// File: rtl/pf_win_meter.sv
module pf_win_meter #(
   parameter int WIN_LEN = 64,
   localparam int PW = $clog2(WIN_LEN),
   localparam int CW = $clog2(WIN_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dmd_valid,
   output logic          win_end,
   output logic [CW-1:0] win_total
);
   localparam logic [PW-1:0] LAST_POS = PW'(WIN_LEN - 1);
   localparam logic [CW-1:0] CNT_SAT  = CW'(WIN_LEN);

   logic [PW-1:0] pos_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;

   assign win_end   = (pos_q == LAST_POS);
   assign cnt_nx    = (dmd_valid && cnt_q != CNT_SAT) ? cnt_q + 1'b1 : cnt_q;
   assign win_total = cnt_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
         cnt_q <= '0;
      end else if (win_end) begin
         pos_q <= '0;
         cnt_q <= '0;
      end else begin
         pos_q <= pos_q + 1'b1;
         cnt_q <= cnt_nx;
      end
   end

   // R5
   cnt_within_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, cnt_q} <= {{(CW-PW){1'b0}}, pos_q}) else $error("demand count ran ahead of window position");
endmodule

// File: rtl/pf_degree_ctl.sv
module pf_degree_ctl
   import pf_throttle_pkg::*;
#(
   parameter int WIN_LEN = 64,
   parameter int MQ_DEPTH = 16,
   parameter int MQ_BUSY = 12,
   parameter int DEG_W = 3,
   localparam int CW = $clog2(WIN_LEN + 1),
   localparam int MQW = $clog2(MQ_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_end,
   input  logic [CW-1:0]    win_total,
   input  logic [MQW-1:0]   mq_count,
   input  logic [CW-1:0]    thr_hi,
   input  logic [CW-1:0]    thr_lo,
   output logic [DEG_W-1:0] deg_q
);
   localparam logic [DEG_W-1:0] DEG_MAX  = '1;
   localparam logic [MQW-1:0]   MQ_LEVEL = MQW'(MQ_BUSY);

   pf_verdict_e verdict;

   always_comb begin
      if (win_total >= thr_hi || mq_count >= MQ_LEVEL) verdict = VERD_DOWN;
      else if (win_total == '0)                        verdict = VERD_FULL;
      else if (win_total <= thr_lo)                    verdict = VERD_UP;
      else                                             verdict = VERD_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         deg_q <= DEG_MAX;
      end else if (win_end) begin
         case (verdict)
            VERD_DOWN: if (deg_q != '0)      deg_q <= deg_q - 1'b1;
            VERD_UP:   if (deg_q != DEG_MAX) deg_q <= deg_q + 1'b1;
            VERD_FULL: deg_q <= DEG_MAX;
            default:   deg_q <= deg_q;
         endcase
      end
   end

   // R10
   deg_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(deg_q)) else $error("degree moved inside a window");

   // R5
   deg_slow_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ({1'b0, deg_q} + {{DEG_W{1'b0}}, 1'b1} >= {1'b0, $past(deg_q)}))
      else $error("degree fell by more than one step");
endmodule

// File: rtl/pf_issue_gate.sv
module pf_issue_gate #(
   parameter int MQ_DEPTH = 16,
   parameter int DEG_W = 3,
   parameter bit ZERO_STOP = 1'b1,
   localparam int MQW = $clog2(MQ_DEPTH + 1)
) (
   input  logic             dmd_valid,
   input  logic             pf_req,
   input  logic [MQW-1:0]   mq_count,
   input  logic [DEG_W-1:0] degree,
   output logic             pf_grant
);
   localparam logic [MQW-1:0] MQ_STOP = MQW'(MQ_DEPTH - 1);

   logic deg_ok;

   if (ZERO_STOP) begin : g_zero_stop
      assign deg_ok = |degree;
   end else begin : g_zero_pass
      assign deg_ok = 1'b1;
   end

   assign pf_grant = pf_req && !dmd_valid && (mq_count < MQ_STOP) && deg_ok;
endmodule

// File: rtl/pf_throttle.sv
module pf_throttle #(
   parameter int WIN_LEN = 64,
   parameter int MQ_DEPTH = 16,
   parameter int MQ_BUSY = 12,
   parameter int DEG_W = 3,
   parameter bit ZERO_STOP = 1'b1,
   localparam int CW = $clog2(WIN_LEN + 1),
   localparam int MQW = $clog2(MQ_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dmd_valid,
   input  logic [MQW-1:0]   mq_count,
   input  logic [CW-1:0]    thr_hi,
   input  logic [CW-1:0]    thr_lo,
   input  logic             pf_req,
   output logic             pf_grant,
   output logic [DEG_W-1:0] pf_degree
);
   localparam logic [MQW-1:0] MQ_STOP = MQW'(MQ_DEPTH - 1);

   if (WIN_LEN < 2) begin : g_bad_win
      $error("WIN_LEN must be at least 2");
   end
   if (MQ_DEPTH < 2) begin : g_bad_depth
      $error("MQ_DEPTH must be at least 2");
   end
   if (MQ_BUSY < 1 || MQ_BUSY >= MQ_DEPTH) begin : g_bad_busy
      $error("MQ_BUSY must lie in 1 .. MQ_DEPTH-1");
   end
   if (DEG_W < 1) begin : g_bad_deg
      $error("DEG_W must be at least 1");
   end

   logic          win_end;
   logic [CW-1:0] win_total;

   pf_win_meter #(.WIN_LEN(WIN_LEN)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .dmd_valid (dmd_valid),
      .win_end   (win_end),
      .win_total (win_total)
   );

   pf_degree_ctl #(
      .WIN_LEN (WIN_LEN),
      .MQ_DEPTH(MQ_DEPTH),
      .MQ_BUSY (MQ_BUSY),
      .DEG_W   (DEG_W)
   ) u_deg (
      .clk       (clk),
      .rst_n     (rst_n),
      .win_end   (win_end),
      .win_total (win_total),
      .mq_count  (mq_count),
      .thr_hi    (thr_hi),
      .thr_lo    (thr_lo),
      .deg_q     (pf_degree)
   );

   pf_issue_gate #(
      .MQ_DEPTH (MQ_DEPTH),
      .DEG_W    (DEG_W),
      .ZERO_STOP(ZERO_STOP)
   ) u_gate (
      .dmd_valid (dmd_valid),
      .pf_req    (pf_req),
      .mq_count  (mq_count),
      .degree    (pf_degree),
      .pf_grant  (pf_grant)
   );

   // R3
   demand_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dmd_valid |-> !pf_grant) else $error("prefetch granted over a demand lookup");

   // R4
   queue_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mq_count >= MQ_STOP) |-> !pf_grant) else $error("prefetch granted with miss queue near full");

   // R2
   grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pf_grant |-> pf_req) else $error("grant without a request");
endmodule

// File: tb/pf_throttle_tb.sv
`timescale 1ns/100ps
module pf_throttle_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dmd_valid = 1'b0;
   logic [4:0] mq_count = '0;
   logic [6:0] thr_hi = 7'd32;
   logic [6:0] thr_lo = 7'd8;
   logic       pf_req = 1'b0;
   logic       pf_grant;
   logic [2:0] pf_degree;

   int n_chk = 0;
   int n_fail = 0;
   int mdeg = 7;

   always #2.5 clk = ~clk;

   pf_throttle u_dut (
      .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .mq_count(mq_count),
      .thr_hi(thr_hi), .thr_lo(thr_lo), .pf_req(pf_req),
      .pf_grant(pf_grant), .pf_degree(pf_degree)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wrap_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // One full window; grant checked every cycle, degree checked after the closing edge
   task automatic run_window(input int ndem, input int mq_end, input string tag);
      int busy;
      for (int i = 0; i < 64; i++) begin
         int mq;
         int exp_g;
         string rq;
         mq = (i == 63) ? mq_end : ((i * 5 + 3) % 17);
         dmd_valid = (i < ndem);
         mq_count  = 5'(mq);
         pf_req    = ((i % 3) != 1);
         #1;
         exp_g = (pf_req && !dmd_valid && mq < 15 && mdeg != 0) ? 1 : 0;
         if (pf_req && dmd_valid)   rq = "R3";
         else if (pf_req && mq >= 15) rq = "R4";
         else if (mdeg == 0)          rq = "R9";
         else                         rq = "R2";
         check(rq, int'(pf_grant), exp_g);
         @(posedge clk);
         @(negedge clk);
      end
      busy = (ndem >= int'(thr_hi) || mq_end >= 12) ? 1 : 0;
      if (busy != 0)                 mdeg = (mdeg > 0) ? mdeg - 1 : 0;
      else if (ndem == 0)            mdeg = 7;
      else if (ndem <= int'(thr_lo)) mdeg = (mdeg < 7) ? mdeg + 1 : 7;
      check(tag, int'(pf_degree), mdeg);
   endtask

   initial begin
      #(5.0 * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      wrap_up();
   end

   initial begin
      repeat (4) @(negedge clk);
      pf_req = 1'b1;
      #1;
      check("R1", int'(pf_degree), 7);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", int'(pf_degree), 7);

      // R5: heavy demand steps down one per window, floor at zero
      for (int k = 0; k < 8; k++) run_window(40, 0, "R5");
      run_window(4, 0, "R7");          // 0 -> 1
      run_window(0, 0, "R6");          // jump to 7
      run_window(0, 0, "R6");          // stays 7
      run_window(20, 0, "R8");         // hold
      run_window(0, 12, "R5");         // queue fill wins over idle: 6
      run_window(0, 11, "R6");         // below queue level: 7
      run_window(64, 0, "R5");         // 6
      run_window(8, 0, "R7");          // lo inclusive: 7
      run_window(32, 0, "R5");         // hi inclusive: 6
      run_window(31, 0, "R8");         // hold
      run_window(9, 0, "R8");          // just above lo: hold
      run_window(8, 0, "R7");          // 7
      run_window(1, 0, "R7");          // ceiling at 7
      thr_hi = 7'd4;
      run_window(5, 0, "R5");          // reprogrammed hi: 6
      run_window(3, 0, "R7");          // 7
      thr_hi = 7'd32;
      // R10: degree unchanged mid-window after a busy pattern
      dmd_valid = 1'b1;
      repeat (30) @(negedge clk);
      #1;
      check("R10", int'(pf_degree), mdeg);
      wrap_up();
   end
endmodule